// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block turns one pending exception into the memory traffic and control events that enter its handler. The exception is named by an 8-bit vector number. From that number the sequencer decides whether the saved program counter is the address of the instruction that faulted or the address of the instruction after it. It then builds a two-longword frame and pushes it below the supervisor stack pointer, reads the handler address from the vector table and loads it into the program counter. Interrupt sampling stays blocked until the handler's first instruction has retired.

The core presents a request together with both candidate PCs, the status register, the stack pointer and the vector table base. The sequencer samples all of them in the accepting cycle and holds them for the whole sequence. Frame writes take one cycle each. The vector read is held until the memory acknowledges it. Reserved vector numbers, and the two reset-time vectors, are refused with a one-cycle flag and cause no memory traffic.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset every output is low or zero and the sequencer is idle (`seq_busy` = 0).
- R2: Vectors 2, 3, 4, 5, 8, 10, 11 and 14 save `fault_pc`. Vectors 9, 12, 24, 32 to 47 and 64 to 255 save `next_pc`.
- R3: A request for vector 0, 1, 6, 7, 13, 15 to 23, 25 to 31 or 48 to 63 raises `bad_vec` for exactly the one cycle after the accepting edge. It produces no write and no read, and `seq_busy` stays low.
- R4: The frame base is the stack pointer rounded down to a multiple of 4, minus 8. In the first cycle after acceptance the saved PC is written at base+4. In the next cycle the second longword is written at base.
- R5: The second longword is {fmt[3:0], 4'b0000, vector[7:0], sr[15:0]} (bits 31:28, 27:24, 23:16, 15:0), where fmt = 4 + sp[1:0].
- R6: Starting in the cycle after the second write, `mem_rd_en` is high with `mem_rd_addr` = vbr + 4*vector. It stays high until an edge that samples `mem_rd_ack` high.
- R7: In the cycle after the edge that samples `mem_rd_ack`, `pc_load` is high for one cycle, with `pc_new` = `mem_rd_data` and `sp_new` = frame base.
- R8: `irq_inhibit` is high from the `pc_load` cycle until an edge samples `insn_retire` high. In the cycle after that edge both `irq_inhibit` and `seq_busy` are low.
- R9: A request that arrives while `seq_busy` is high is ignored. The frame, the read address and the loaded PC all come from the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception pending, sampled while idle |
| exc_vec | input | 8 | Vector number of the pending exception |
| fault_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | PC of the following instruction |
| sr_in | input | 16 | Status register to be saved |
| sp_in | input | 32 | Supervisor stack pointer before entry |
| vbr_in | input | 32 | Vector table base address |
| insn_retire | input | 1 | An instruction retired this cycle |
| mem_wr_en | output | 1 | Frame write strobe |
| mem_wr_addr | output | 32 | Frame write byte address |
| mem_wr_data | output | 32 | Frame write longword |
| mem_rd_en | output | 1 | Vector table read request |
| mem_rd_addr | output | 32 | Vector table entry address |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Handler address from the table |
| pc_load | output | 1 | One-cycle strobe to load the new PC |
| pc_new | output | 32 | Handler address |
| sp_new | output | 32 | Stack pointer after the push |
| seq_busy | output | 1 | Sequence in progress |
| irq_inhibit | output | 1 | Interrupt sampling blocked |
| bad_vec | output | 1 | Refused vector, one-cycle pulse |

## Verification
If a request is accepted at edge E, the PC write is due in the cycle after E, the second frame write one cycle later, and the table read from the third cycle until the acknowledge. `pc_load` is due in the cycle after the acknowledging edge, and `seq_busy` falls in the cycle after the retiring edge. A refused vector shows `bad_vec` only in the cycle after E. The bench drives inputs on the falling edge. After each rising edge it compares every output against a reference computed from the vector ranges, so each result is checked in exactly the cycle it is due. It varies the read latency and the retire delay, and injects competing requests mid-sequence.

// File: rtl/exc_entry_pkg.sv
// Shared types for the exception entry sequencer.
// Assumes a 32-bit longword machine with a 16-bit status register.
package exc_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PC,
        ST_WR_FV,
        ST_FETCH,
        ST_INHIBIT
    } seq_state_t;

    typedef enum logic [1:0] {
        VK_INVALID,
        VK_FAULT,
        VK_NEXT
    } vec_kind_t;

    localparam int FMT_W       = 4;
    localparam int FMT_BASE    = 4;
    localparam int FRAME_BYTES = 8;
    localparam int LONG_BYTES  = 4;

endpackage

// File: rtl/exc_vec_classify.sv
// Sorts a vector number into refused, fault-PC or next-PC classes.
// Assumes vectors above MAX_VEC are refused; purely combinational.
module exc_vec_classify
    import exc_entry_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int MAX_VEC = 255
) (
    input  logic [VEC_W-1:0] vec_i,
    output vec_kind_t        kind_o
);

    logic [31:0] v;
    assign v = 32'(vec_i);

    // Range decode of the vector number into its class.
    always_comb begin
        kind_o = VK_NEXT;
        if (v < 2 || v == 6 || v == 7 || v == 13 ||
            (v >= 15 && v <= 23) || (v >= 25 && v <= 31) ||
            (v >= 48 && v <= 63) || v > MAX_VEC) begin
            kind_o = VK_INVALID;
        end else if ((v >= 2 && v <= 5) || v == 8 || v == 10 ||
                     v == 11 || v == 14) begin
            kind_o = VK_FAULT;
        end
    end

endmodule

// File: rtl/exc_frame_build.sv
// Forms the two frame longwords, the frame base and the table address.
// Assumes SR_W + format/vector word width equals XLEN; combinational.
module exc_frame_build
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8,
    parameter int SR_W  = 16
) (
    input  logic [VEC_W-1:0] vec_i,
    input  vec_kind_t        kind_i,
    input  logic [XLEN-1:0]  fault_pc_i,
    input  logic [XLEN-1:0]  next_pc_i,
    input  logic [SR_W-1:0]  sr_i,
    input  logic [XLEN-1:0]  sp_i,
    input  logic [XLEN-1:0]  vbr_i,
    output logic [XLEN-1:0]  pc_word_o,
    output logic [XLEN-1:0]  fv_word_o,
    output logic [XLEN-1:0]  base_o,
    output logic [XLEN-1:0]  vaddr_o
);

    localparam int FV_W  = XLEN - SR_W;
    localparam int PAD_W = FV_W - FMT_W - VEC_W;

    logic [FMT_W-1:0] fmt;
    logic [FV_W-1:0]  fv_half;
    logic [XLEN-1:0]  sp_aligned;

    // Format nibble records how far the stack pointer was off alignment.
    assign fmt = FMT_W'(FMT_BASE) + FMT_W'(sp_i[1:0]);

    // Pack the format/vector half; padding only when the widths leave room.
    generate
        if (PAD_W > 0) begin : g_pad
            assign fv_half = {fmt, {PAD_W{1'b0}}, vec_i};
        end else begin : g_nopad
            assign fv_half = {fmt, vec_i};
        end
    endgenerate

    // Select the saved PC by vector class.
    assign pc_word_o  = (kind_i == VK_FAULT) ? fault_pc_i : next_pc_i;
    assign fv_word_o  = {fv_half, sr_i};
    assign sp_aligned = {sp_i[XLEN-1:2], 2'b00};
    assign base_o     = sp_aligned - XLEN'(FRAME_BYTES);
    assign vaddr_o    = vbr_i + (XLEN'(vec_i) << 2);

endmodule

// File: rtl/exc_entry_fsm.sv
// Control sequence: push PC, push format/SR, fetch vector, hold inhibit.
// Assumes the request is only looked at while idle; one write per cycle.
module exc_entry_fsm
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       refuse_i,
    input  logic       rd_ack_i,
    input  logic       retire_i,
    output seq_state_t state_o,
    output logic       accept_o,
    output logic       fetch_done_o,
    output logic       bad_o
);

    seq_state_t state_q, state_d;
    logic       bad_q;

    assign accept_o     = (state_q == ST_IDLE) && req_i && !refuse_i;
    assign fetch_done_o = (state_q == ST_FETCH) && rd_ack_i;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (accept_o) state_d = ST_WR_PC;
            ST_WR_PC:   state_d = ST_WR_FV;
            ST_WR_FV:   state_d = ST_FETCH;
            ST_FETCH:   if (rd_ack_i) state_d = ST_INHIBIT;
            ST_INHIBIT: if (retire_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and the refused-vector pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            bad_q   <= (state_q == ST_IDLE) && req_i && refuse_i;
        end
    end

    assign state_o = state_q;
    assign bad_o   = bad_q;

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top: classifies, captures, drives memory.
// Assumes frame writes always complete in their cycle and the vector
// read is held until acknowledged.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8,
    parameter int SR_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic [XLEN-1:0]  fault_pc,
    input  logic [XLEN-1:0]  next_pc,
    input  logic [SR_W-1:0]  sr_in,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  vbr_in,
    input  logic             insn_retire,
    output logic             mem_wr_en,
    output logic [XLEN-1:0]  mem_wr_addr,
    output logic [XLEN-1:0]  mem_wr_data,
    output logic             mem_rd_en,
    output logic [XLEN-1:0]  mem_rd_addr,
    input  logic             mem_rd_ack,
    input  logic [XLEN-1:0]  mem_rd_data,
    output logic             pc_load,
    output logic [XLEN-1:0]  pc_new,
    output logic [XLEN-1:0]  sp_new,
    output logic             seq_busy,
    output logic             irq_inhibit,
    output logic             bad_vec
);

    localparam int MAX_VEC = (1 << VEC_W) - 1;

    vec_kind_t       kind;
    seq_state_t      state;
    logic            accept, fetch_done;
    logic [XLEN-1:0] pc_word, fv_word, base, vaddr;
    logic [XLEN-1:0] pc_word_q, fv_word_q, base_q, vaddr_q;
    logic [XLEN-1:0] pc_new_q;
    logic            pc_load_q;

    exc_vec_classify #(.VEC_W(VEC_W), .MAX_VEC(MAX_VEC)) u_cls (
        .vec_i  (exc_vec),
        .kind_o (kind)
    );

    exc_frame_build #(.XLEN(XLEN), .VEC_W(VEC_W), .SR_W(SR_W)) u_frm (
        .vec_i      (exc_vec),
        .kind_i     (kind),
        .fault_pc_i (fault_pc),
        .next_pc_i  (next_pc),
        .sr_i       (sr_in),
        .sp_i       (sp_in),
        .vbr_i      (vbr_in),
        .pc_word_o  (pc_word),
        .fv_word_o  (fv_word),
        .base_o     (base),
        .vaddr_o    (vaddr)
    );

    exc_entry_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (exc_req),
        .refuse_i     (kind == VK_INVALID),
        .rd_ack_i     (mem_rd_ack),
        .retire_i     (insn_retire),
        .state_o      (state),
        .accept_o     (accept),
        .fetch_done_o (fetch_done),
        .bad_o        (bad_vec)
    );

    // Hold the frame contents and addresses of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_word_q <= '0;
            fv_word_q <= '0;
            base_q    <= '0;
            vaddr_q   <= '0;
        end else if (accept) begin
            pc_word_q <= pc_word;
            fv_word_q <= fv_word;
            base_q    <= base;
            vaddr_q   <= vaddr;
        end
    end

    // Latch the handler address and strobe the PC load once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_new_q  <= '0;
            pc_load_q <= 1'b0;
        end else begin
            pc_load_q <= fetch_done;
            if (fetch_done) pc_new_q <= mem_rd_data;
        end
    end

    // Memory request decode from the sequence state.
    always_comb begin
        mem_wr_en   = 1'b0;
        mem_wr_addr = '0;
        mem_wr_data = '0;
        if (state == ST_WR_PC) begin
            mem_wr_en   = 1'b1;
            mem_wr_addr = base_q + XLEN'(LONG_BYTES);
            mem_wr_data = pc_word_q;
        end else if (state == ST_WR_FV) begin
            mem_wr_en   = 1'b1;
            mem_wr_addr = base_q;
            mem_wr_data = fv_word_q;
        end
    end

    assign mem_rd_en   = (state == ST_FETCH);
    assign mem_rd_addr = (state == ST_FETCH) ? vaddr_q : '0;
    assign pc_load     = pc_load_q;
    assign pc_new      = pc_new_q;
    assign sp_new      = base_q;
    assign seq_busy    = (state != ST_IDLE);
    assign irq_inhibit = (state == ST_INHIBIT);

endmodule

// File: rtl/exc_entry_chk.sv
// Temporal checks on the sequencer ports, bound into every instance.
// Assumes the synchronous active-low reset of the top module.
module exc_entry_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_wr_en,
    input logic [XLEN-1:0] mem_wr_addr,
    input logic            mem_rd_en,
    input logic            pc_load,
    input logic            seq_busy,
    input logic            irq_inhibit,
    input logic            bad_vec,
    input logic            insn_retire
);

    a_r3_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bad_vec |-> (!seq_busy && !mem_wr_en && !mem_rd_en));

    a_r4_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> seq_busy);

    a_r4_start_writes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> mem_wr_en);

    a_r4_frame_descends: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en) |=> (mem_wr_en &&
            mem_wr_addr == $past(mem_wr_addr) - XLEN'(4)));

    a_r6_read_alone: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (!mem_wr_en && seq_busy));

    a_r7_load_once: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

    a_r8_load_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> irq_inhibit);

    a_r8_hold_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_inhibit && !insn_retire) |=> irq_inhibit);

    a_r8_inhibit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq_inhibit |-> seq_busy);

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_rd_en   (mem_rd_en),
    .pc_load     (pc_load),
    .seq_busy    (seq_busy),
    .irq_inhibit (irq_inhibit),
    .bad_vec     (bad_vec),
    .insn_retire (insn_retire)
);

// File: tb/exc_entry_seq_tb_top.sv
// Bench: behavioural per-cycle reference for the entry sequencer.
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [7:0]  exc_vec = '0;
    logic [31:0] fault_pc = '0, next_pc = '0, sp_in = '0, vbr_in = '0;
    logic [15:0] sr_in = '0;
    logic        insn_retire = 1'b0;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_en, mem_rd_en, pc_load, seq_busy, irq_inhibit, bad_vec;
    logic [31:0] mem_wr_addr, mem_wr_data, mem_rd_addr, pc_new, sp_new;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec),
        .fault_pc(fault_pc), .next_pc(next_pc), .sr_in(sr_in),
        .sp_in(sp_in), .vbr_in(vbr_in), .insn_retire(insn_retire),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .pc_load(pc_load), .pc_new(pc_new),
        .sp_new(sp_new), .seq_busy(seq_busy), .irq_inhibit(irq_inhibit),
        .bad_vec(bad_vec)
    );

    // Vector class per the requirement ranges: 0 refused, 1 fault, 2 next.
    function automatic int ref_kind(input int v);
        if (v == 2 || v == 3 || v == 4 || v == 5 || v == 8 ||
            v == 10 || v == 11 || v == 14) return 1;
        if (v == 9 || v == 12 || v == 24 || (v >= 32 && v <= 47) ||
            v >= 64) return 2;
        return 0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Compare the control outputs of the current cycle.
    task automatic ctl(input string req, input bit busy, input bit wr,
                       input bit rd, input bit ld, input bit inh, input bit bad);
        check(req, "seq_busy",    32'(seq_busy),    32'(busy));
        check(req, "mem_wr_en",   32'(mem_wr_en),   32'(wr));
        check(req, "mem_rd_en",   32'(mem_rd_en),   32'(rd));
        check(req, "pc_load",     32'(pc_load),     32'(ld));
        check(req, "irq_inhibit", 32'(irq_inhibit), 32'(inh));
        check(req, "bad_vec",     32'(bad_vec),     32'(bad));
    endtask

    // One request end to end; lat = extra cycles before the read ack,
    // hold = cycles of inhibit before retire, poke = competing requests.
    task automatic run_exc(input int v, input logic [31:0] fpc,
                           input logic [31:0] npc, input logic [15:0] sr,
                           input logic [31:0] sp, input logic [31:0] vbr,
                           input int lat, input int hold, input bit poke);
        logic [31:0] base, saved, fvw, vaddr, handler;
        int k;
        k       = ref_kind(v);
        base    = {sp[31:2], 2'b00} - 32'd8;
        saved   = (k == 1) ? fpc : npc;
        fvw     = {4'(4 + sp[1:0]), 4'h0, 8'(v), sr};
        vaddr   = vbr + 32'(v) * 32'd4;
        handler = 32'h4000_0000 ^ (32'(v) << 8) ^ fpc;

        @(negedge clk);
        exc_req = 1'b1; exc_vec = 8'(v); fault_pc = fpc; next_pc = npc;
        sr_in = sr; sp_in = sp; vbr_in = vbr;
        @(negedge clk);
        exc_req = 1'b0;
        if (k == 0) begin
            ctl("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            @(negedge clk);
            ctl("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            return;
        end
        ctl("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4", "pc addr", mem_wr_addr, base + 32'd4);
        check("R2", "saved pc", mem_wr_data, saved);
        if (poke) begin
            exc_req = 1'b1; exc_vec = 8'd3; fault_pc = 32'hDEAD_0000;
            next_pc = 32'hBEEF_0000; sp_in = 32'h0000_1003;
            vbr_in = 32'h7000_0000; sr_in = 16'hFFFF;
        end
        @(negedge clk);
        ctl("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4", "fv addr", mem_wr_addr, base);
        check("R5", "fv word", mem_wr_data, fvw);
        for (int i = 0; i <= lat; i++) begin
            @(negedge clk);
            ctl("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            check("R6", "rd addr", mem_rd_addr, vaddr);
            if (i == lat) begin
                mem_rd_ack = 1'b1; mem_rd_data = handler;
            end
        end
        @(negedge clk);
        mem_rd_ack = 1'b0; mem_rd_data = 32'h0;
        ctl("R7", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R7", "pc_new", pc_new, handler);
        check("R7", "sp_new", sp_new, base);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            ctl("R8", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        end
        insn_retire = 1'b1;
        @(negedge clk);
        insn_retire = 1'b0;
        if (poke) exc_req = 1'b0;
        ctl(poke ? "R9" : "R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        ctl("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1", "pc_new", pc_new, 32'h0);
        check("R1", "sp_new", sp_new, 32'h0);

        // R2: fault and next classes over several vectors
        run_exc(2,   32'h0000_1000, 32'h0000_1004, 16'h2700, 32'h2000_0100, 32'h0, 0, 0, 1'b0);
        run_exc(9,   32'h0000_2000, 32'h0000_2002, 16'h2000, 32'h2000_0200, 32'h0, 1, 1, 1'b0);
        run_exc(14,  32'h0000_3000, 32'h0000_3006, 16'h2100, 32'h2000_0300, 32'h8000_0000, 0, 2, 1'b0);
        run_exc(24,  32'h0000_4000, 32'h0000_4002, 16'h2300, 32'h2000_0400, 32'h0, 2, 0, 1'b0);
        run_exc(33,  32'h0000_5000, 32'h0000_5002, 16'h0000, 32'h2000_0500, 32'h0010_0000, 0, 0, 1'b0);
        run_exc(11,  32'h0000_6000, 32'h0000_6002, 16'h2704, 32'h2000_0600, 32'h0, 0, 0, 1'b0);
        run_exc(64,  32'h0000_7000, 32'h0000_7004, 16'h2500, 32'h2000_0700, 32'h0, 3, 1, 1'b0);
        run_exc(255, 32'h0000_8000, 32'h0000_8002, 16'hA71F, 32'h2000_0800, 32'hFFFF_F000, 0, 0, 1'b0);
        // R5: misaligned stack pointers give format 5, 6, 7
        run_exc(4,   32'h0000_9000, 32'h0000_9002, 16'h2700, 32'h2000_0901, 32'h0, 0, 0, 1'b0);
        run_exc(47,  32'h0000_A000, 32'h0000_A002, 16'h2700, 32'h2000_0A02, 32'h0, 0, 0, 1'b0);
        run_exc(8,   32'h0000_B000, 32'h0000_B002, 16'h2700, 32'h0000_0003, 32'h0, 1, 0, 1'b0);
        // R9: competing requests during a sequence are ignored
        run_exc(12,  32'h0000_C000, 32'h0000_C002, 16'h2200, 32'h2000_0C00, 32'h0000_4000, 2, 2, 1'b1);
        // R3: refused vectors
        run_exc(0,   32'h1, 32'h2, 16'h0, 32'h2000_0000, 32'h0, 0, 0, 1'b0);
        run_exc(1,   32'h1, 32'h2, 16'h0, 32'h2000_0000, 32'h0, 0, 0, 1'b0);
        run_exc(6,   32'h1, 32'h2, 16'h0, 32'h2000_0000, 32'h0, 0, 0, 1'b0);
        run_exc(13,  32'h1, 32'h2, 16'h0, 32'h2000_0000, 32'h0, 0, 0, 1'b0);
        run_exc(20,  32'h1, 32'h2, 16'h0, 32'h2000_0000, 32'h0, 0, 0, 1'b0);
        run_exc(31,  32'h1, 32'h2, 16'h0, 32'h2000_0000, 32'h0, 0, 0, 1'b0);
        run_exc(48,  32'h1, 32'h2, 16'h0, 32'h2000_0000, 32'h0, 0, 0, 1'b0);
        run_exc(63,  32'h1, 32'h2, 16'h0, 32'h2000_0000, 32'h0, 0, 0, 1'b0);
        // R2: a valid request right after a refused one is still taken
        run_exc(5,   32'h0000_D000, 32'h0000_D002, 16'h2700, 32'h2000_0D00, 32'h0, 0, 0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule